// File: doc/BRIEF.md
# Multi-Rate Three-Stage Task Pipeline

This block is a streaming kernel made of three processing stages in a fixed series order: stage A, then stage B, then stage C. Each stage holds one data unit for a fixed number of clock cycles, set by its own parameter, and adds a stage constant to that unit. Small streaming FIFOs join A to B and B to C. A stage writes into the FIFO after it only when that FIFO has room. A stage takes a unit from the FIFO before it only when that FIFO holds data. Stages never handshake with each other directly. The kernel input and the kernel output both use valid/ready handshakes.

A mode input selects between two schedules. In pipelined mode (`serial_mode` = 0) stage A takes new input while B and C are still busy. The steady output rate is then set by the slowest stage. In serialized mode (`serial_mode` = 1) a new unit enters only once the previous one has left the kernel, so the interval is the sum of the stage intervals. A free-running cycle counter and an output counter are brought out so that the interval of each mode can be measured at the ports.

Top module: `task_chain`

## Requirements
- R1: Every output unit equals its input unit plus KA+KB+KC, modulo 2^W (defaults 0x0001+0x0010+0x0100 = 0x0111), and units leave in the order in which they were accepted.
- R2: Stage A, B and C hold each unit for TA, TB and TC cycles respectively (defaults 3, 5, 2), so that no stage starts more than one unit per its own interval.
- R3: In pipelined mode (`serial_mode` = 0) with `out_ready` held high and input always offered, successive outputs are exactly max(TA,TB,TC) cycles apart (5 by default) from the second output on.
- R4: In serialized mode (`serial_mode` = 1), `in_ready` is low while a unit is inside the kernel, unless that unit is leaving through an output handshake in the same cycle. With `out_ready` high, outputs are then TA+TB+TC+2 cycles apart (12 by default).
- R5: With `out_ready` high and the kernel empty on entry, the cycle of an output handshake is TA+TB+TC+2 cycles after the cycle of the matching input handshake, in both modes. The 2 is one pass-through cycle for each FIFO.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. Backpressure loses no unit and duplicates none.
- R7: While `rst_n` is low, `in_ready` and `out_valid` are low and both counters read 0. A few cycles after release, `in_ready` is high.
- R8: `cycle_count` increases by exactly 1 every clock once reset has ended. `out_count` increases by 1 on each output handshake and is otherwise unchanged.
- R9: With `out_ready` held low, the kernel accepts exactly 3 + 2*DEPTH units (7 by default; one per stage and DEPTH per FIFO) and then holds `in_ready` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| serial_mode | input | 1 | 0 = pipelined, 1 = serialized |
| in_valid | input | 1 | Input unit offered |
| in_data | input | W | Input unit |
| in_ready | output | 1 | Kernel accepts the input unit this cycle |
| out_valid | output | 1 | Output unit available |
| out_data | output | W | Output unit |
| out_ready | input | 1 | Downstream takes the output unit this cycle |
| cycle_count | output | CNT_W | Clock cycles since reset ended |
| out_count | output | CNT_W | Output handshakes since reset |

## Verification
The hardest situation to reach is the kernel full to the brim: every stage is holding a finished unit and both FIFOs are full. That state exercises the full-FIFO stall of each producer and the exact capacity limit. The stimulus reaches it by holding `out_ready` low while offering input on every cycle, then counts the accepted units. It then releases the output with a pseudo-random ready pattern, so that stalls land at every point of the chain. A second hard case is serialized mode under intermittent backpressure. There the bench tracks the number of units in flight on each cycle and checks that `in_ready` never rises early.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic {
    SCHED_PIPE   = 1'b0,
    SCHED_SERIAL = 1'b1
  } sched_e;

  function automatic int unsigned fit_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tc_fifo.sv
module tc_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  input  logic [W-1:0] wr_data,
  output logic         wr_ready,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  input  logic         rd_ready
);
  localparam int AW = tc_pkg::fit_bits(DEPTH);
  localparam int NW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [NW-1:0] fill_q, fill_d;
  logic          push, pop;

  assign wr_ready = (fill_q != NW'(DEPTH));
  assign rd_valid = (fill_q != '0);
  assign rd_data  = mem[rp_q];
  assign push     = wr_valid & wr_ready;
  assign pop      = rd_valid & rd_ready;

  always_comb begin
    wp_d   = wp_q;
    rp_d   = rp_q;
    fill_d = fill_q;
    if (push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
    if (pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
    case ({push, pop})
      2'b10:   fill_d = fill_q + NW'(1);
      2'b01:   fill_d = fill_q - NW'(1);
      default: fill_d = fill_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      fill_q <= '0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      fill_q <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wr_data;
  end
endmodule

// File: rtl/tc_stage.sv
module tc_stage #(
  parameter int           W = 16,
  parameter int           T = 3,
  parameter logic [W-1:0] K = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  localparam int CW = tc_pkg::fit_bits(T);

  logic          busy_q, busy_d;
  logic [CW-1:0] left_q, left_d;
  logic [W-1:0]  hold_q, hold_d;
  logic          done, take, leave;

  assign done      = busy_q & (left_q == '0);
  assign leave     = done & out_ready;
  assign in_ready  = ~busy_q | leave;
  assign take      = in_valid & in_ready;
  assign out_valid = done;
  assign out_data  = hold_q;

  always_comb begin
    busy_d = busy_q;
    left_d = left_q;
    hold_d = hold_q;
    if (leave) busy_d = 1'b0;
    if (take) begin
      busy_d = 1'b1;
      left_d = CW'(T - 1);
      hold_d = in_data + K;
    end else if (busy_q && left_q != '0) begin
      left_d = left_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      hold_q <= '0;
    end else begin
      busy_q <= busy_d;
      left_q <= left_d;
      hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/task_chain.sv
module task_chain #(
  parameter int           W     = 16,
  parameter int           TA    = 3,
  parameter int           TB    = 5,
  parameter int           TC    = 2,
  parameter logic [W-1:0] KA    = 16'h0001,
  parameter logic [W-1:0] KB    = 16'h0010,
  parameter logic [W-1:0] KC    = 16'h0100,
  parameter int           DEPTH = 2,
  parameter int           CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             serial_mode,
  input  logic             in_valid,
  input  logic [W-1:0]     in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  input  logic             out_ready,
  output logic [CNT_W-1:0] cycle_count,
  output logic [CNT_W-1:0] out_count
);
  import tc_pkg::*;

  localparam int NSTAGE = 3;
  localparam int CAP    = NSTAGE + 2 * DEPTH;
  localparam int FW     = $clog2(CAP + 2);
  localparam int           T_OF [NSTAGE] = '{TA, TB, TC};
  localparam logic [W-1:0] K_OF [NSTAGE] = '{KA, KB, KC};

  logic [1:0] rsync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ok = rsync_q[1];

  logic         s_iv [NSTAGE];
  logic [W-1:0] s_id [NSTAGE];
  logic         s_ir [NSTAGE];
  logic         s_ov [NSTAGE];
  logic [W-1:0] s_od [NSTAGE];
  logic         s_or [NSTAGE];

  genvar g;
  generate
    for (g = 0; g < NSTAGE; g++) begin : g_stage
      tc_stage #(.W(W), .T(T_OF[g]), .K(K_OF[g])) u_stage (
        .clk(clk), .rst_n(rst_ok),
        .in_valid(s_iv[g]), .in_data(s_id[g]), .in_ready(s_ir[g]),
        .out_valid(s_ov[g]), .out_data(s_od[g]), .out_ready(s_or[g])
      );
    end
    for (g = 0; g < NSTAGE - 1; g++) begin : g_link
      tc_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_ok),
        .wr_valid(s_ov[g]), .wr_data(s_od[g]), .wr_ready(s_or[g]),
        .rd_valid(s_iv[g+1]), .rd_data(s_id[g+1]), .rd_ready(s_ir[g+1])
      );
    end
  endgenerate

  sched_e        sched;
  logic [FW-1:0] inflight_q, inflight_d;
  logic          out_fire, in_fire, admit;

  assign sched     = sched_e'(serial_mode);
  assign out_fire  = s_ov[NSTAGE-1] & out_ready;
  assign admit     = rst_ok & ((sched == SCHED_PIPE) ||
                               (inflight_q == '0) ||
                               (inflight_q == FW'(1) && out_fire));
  assign s_iv[0]   = in_valid & admit;
  assign s_id[0]   = in_data;
  assign in_ready  = s_ir[0] & admit;
  assign in_fire   = in_valid & in_ready;
  assign s_or[NSTAGE-1] = out_ready;
  assign out_valid = s_ov[NSTAGE-1];
  assign out_data  = s_od[NSTAGE-1];

  logic [CNT_W-1:0] cyc_d, ocnt_d;

  always_comb begin
    inflight_d = inflight_q;
    case ({in_fire, out_fire})
      2'b10:   inflight_d = inflight_q + FW'(1);
      2'b01:   inflight_d = inflight_q - FW'(1);
      default: inflight_d = inflight_q;
    endcase
    cyc_d  = cycle_count + CNT_W'(1);
    ocnt_d = out_fire ? out_count + CNT_W'(1) : out_count;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      inflight_q  <= '0;
      cycle_count <= '0;
      out_count   <= '0;
    end else begin
      inflight_q  <= inflight_d;
      cycle_count <= cyc_d;
      out_count   <= ocnt_d;
    end
  end
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int W     = 16,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             serial_mode,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [W-1:0]     out_data,
  input logic [CNT_W-1:0] cycle_count,
  input logic [CNT_W-1:0] out_count
);
  // R6
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid && !out_ready |=> out_valid);

  // R6
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid && !out_ready |=> $stable(out_data));

  // R4
  serial_gate_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    serial_mode && out_valid && !out_ready |-> !in_ready);

  // R8
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> cycle_count == $past(cycle_count) + CNT_W'(1));

  // R8
  out_count_up_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid && out_ready |=> out_count == $past(out_count) + CNT_W'(1));

  // R8
  out_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(out_valid && out_ready) |=> $stable(out_count));
endmodule

bind task_chain tc_checker #(.W(W), .CNT_W(CNT_W)) u_tc_checker (
  .clk(clk), .rst_ok(rst_ok), .serial_mode(serial_mode),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .cycle_count(cycle_count), .out_count(out_count)
);

// File: tb/task_chain_bench.sv
`timescale 1ns/1ps
module task_chain_bench;
  localparam int W = 16, TA = 3, TB = 5, TC = 2, DEPTH = 2, CNT_W = 32;
  localparam logic [W-1:0] KSUM = 16'h0111;
  localparam int SUM_LAT = TA + TB + TC + 2;
  localparam int CAP = 3 + 2 * DEPTH;

  logic clk = 1'b0, rst_n = 1'b0, serial_mode = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0, out_data;
  logic in_ready, out_valid;
  logic [CNT_W-1:0] cycle_count, out_count;

  task_chain u_task_chain (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .cycle_count(cycle_count), .out_count(out_count)
  );

  always #10 clk = ~clk;

  int n_vec = 0, n_fail = 0;
  bit finished = 0;

  logic [W-1:0] exp_q[$];
  longint in_t[$], out_t[$];
  int send_idx, send_total, rdy_mode, n_out, inflight;
  logic [W-1:0] base;
  bit offer = 1, have_prev = 0, held = 0;
  logic [W-1:0] held_data;
  longint prev_cyc;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    longint cur;
    bit ofire, ifire;
    @(negedge clk);
    in_valid  = offer && (send_idx < send_total);
    in_data   = base + W'(send_idx);
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : lfsr[0];
    #5;
    cur = longint'(cycle_count);
    if (have_prev) chk(cur == prev_cyc + 1, "R8 cycle step", cur, prev_cyc + 1);
    chk(out_count == CNT_W'(n_out), "R8 out_count", longint'(out_count), n_out);
    if (held) begin
      chk(out_valid == 1'b1, "R6 valid hold", out_valid, 1);
      chk(out_data == held_data, "R6 data hold", out_data, held_data);
    end
    ofire = out_valid && out_ready;
    ifire = in_valid && in_ready;
    if (serial_mode && inflight > 0 && !ofire)
      chk(in_ready == 1'b0, "R4 serial gate", in_ready, 0);
    if (ofire) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 extra output", out_data, 0);
      else chk(out_data == exp_q[0], "R1 data/order", out_data, exp_q[0]);
      if (exp_q.size() > 0) void'(exp_q.pop_front());
      out_t.push_back(cur);
      n_out++;
      inflight--;
    end
    if (ifire) begin
      exp_q.push_back(in_data + KSUM);
      in_t.push_back(cur);
      send_idx++;
      inflight++;
    end
    held = out_valid && !out_ready;
    held_data = out_data;
    prev_cyc = cur;
    have_prev = 1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic start_phase(input bit smode, input int total, input logic [W-1:0] b, input int rmode);
    serial_mode = smode;
    send_idx = 0; send_total = total; base = b; rdy_mode = rmode;
    in_t.delete(); out_t.delete();
  endtask

  task automatic drain();
    while (exp_q.size() > 0 || send_idx < send_total) step();
  endtask

  initial begin
    send_idx = 0; send_total = 0; rdy_mode = 0; n_out = 0; inflight = 0; base = '0;
    repeat (4) @(negedge clk);
    #5;
    chk(in_ready == 1'b0, "R7 in_ready in reset", in_ready, 0);
    chk(out_valid == 1'b0, "R7 out_valid in reset", out_valid, 0);
    chk(cycle_count == '0, "R7 cycle_count in reset", cycle_count, 0);
    chk(out_count == '0, "R7 out_count in reset", out_count, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #5;
    chk(in_ready == 1'b1, "R7 ready after release", in_ready, 1);

    // Serialized, no backpressure: R4 interval, R5 latency
    start_phase(1'b1, 6, 16'h0100, 0);
    drain();
    for (int i = 0; i < 6; i++)
      chk(out_t[i] - in_t[i] == SUM_LAT, "R5 serial latency", out_t[i] - in_t[i], SUM_LAT);
    for (int i = 1; i < 6; i++)
      chk(out_t[i] - out_t[i-1] == SUM_LAT, "R4 serial interval", out_t[i] - out_t[i-1], SUM_LAT);

    // Pipelined, no backpressure: R3 interval, R5 latency, R2 slowest stage
    start_phase(1'b0, 10, 16'h2000, 0);
    drain();
    chk(out_t[0] - in_t[0] == SUM_LAT, "R5 pipe latency", out_t[0] - in_t[0], SUM_LAT);
    for (int i = 1; i < 10; i++)
      chk(out_t[i] - out_t[i-1] == TB, "R3 R2 pipe interval", out_t[i] - out_t[i-1], TB);

    // Full stall: R9 capacity, then random release: R6, R1 with wrap
    start_phase(1'b0, 12, 16'hFFF8, 1);
    repeat (60) step();
    chk(send_idx == CAP, "R9 capacity", send_idx, CAP);
    chk(in_ready == 1'b0, "R9 in_ready low when full", in_ready, 0);
    chk(out_valid == 1'b1, "R6 output waiting", out_valid, 1);
    rdy_mode = 2;
    drain();
    chk(n_out == 6 + 10 + 12, "R6 no loss or duplicate", n_out, 28);

    // Serialized with random backpressure: R4 gate per cycle
    start_phase(1'b1, 5, 16'h7F00, 2);
    drain();
    chk(exp_q.size() == 0, "R1 queue empty", exp_q.size(), 0);
    chk(n_out == 33, "R6 final count", n_out, 33);
    repeat (3) step();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_vec++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule